// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block sits beside the fetch stage of a small 8-bit core and decides when the core is interrupted. It arbitrates among fourteen ranked interrupt sources. Rank 0 is the software trap, which cannot be masked. Ranks 1 to 13 are maskable, and each has its own pending flag and enable flag. A global enable gates all of the maskable sources.

When the core reports that it is about to start an instruction, the block may take an interrupt. It does so when the global enable is set, at least one maskable source is active, and no trap service is running. It then forces the interrupt pseudo-opcode into the instruction register in place of the fetched one. After that it runs a fixed entry sequence:

- The global enable is cleared.
- The return address is pushed to the stack as bytes.
- The program counter is loaded with the single service address.

The winning source is latched when the interrupt is taken. It is shown as an index, and also as a byte offset into a table of two-byte vector slots, so that the service routine can dispatch on it.

The stack and the program counter are external. The block drives them through simple write strobes.

Top module: `vint_entry`

## Requirements
- R1: After reset the global enable, all pending and enable flags, `busy_o`, `take_o`, `push_we_o`, `pc_load_o` and `done_o` are 0, and `ir_o` equals `opcode_i`.
- R2: A one-cycle pulse on bit k of `req_i` sets the pending flag of source k+1. A 1 on bit k of `clr_i` clears it. When both arrive in the same cycle, the flag ends up set. A write on `en_wr_i` loads all enable flags from `en_data_i`.
- R3: `take_o` is 1 only in a cycle where all of these hold: `boundary_i` is 1, the global enable is 1, some source has both its pending and enable flags set, `busy_o` is 0, and no trap service is running.
- R4: Of the active sources, the one with the lowest rank number wins. Its rank appears on `src_idx_o` from the cycle after the take and stays constant until `done_o`.
- R5: In a cycle with `take_o` high, `ir_o` is 0x00. In every other cycle, `ir_o` equals `opcode_i`.
- R6: The global enable reads 0 from the cycle after the take. A `gie_set_i` pulse sets it, unless a take occurs in the same cycle.
- R7: The take cycle counts as sequence cycle 1. In cycle 2, `push_we_o` writes bits 7:0 of the `pc_ret_i` value captured at the take. In cycle 3, it writes bits 15:8. No other cycle writes.
- R8: `busy_o` is high for sequence cycles 2 through 7. In cycle 7, `pc_load_o` and `done_o` pulse and `pc_o` is 0x00FF, so the whole entry takes 7 cycles.
- R9: After a `trap_enter_i` pulse and until a `trap_exit_i` pulse, no maskable interrupt is taken. `ir_o` keeps passing `opcode_i` through during that time.
- R10: `vec_ofs_o` equals twice `src_idx_o`, which is the offset of the winner's two-byte vector slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 13 | Request pulses; bit k is source k+1 |
| clr_i | input | 13 | Write-one-to-clear of pending flags |
| en_wr_i | input | 1 | Load the enable flags |
| en_data_i | input | 13 | New enable flag values |
| gie_set_i | input | 1 | Set the global enable |
| trap_enter_i | input | 1 | Software trap service starts |
| trap_exit_i | input | 1 | Software trap service ends |
| boundary_i | input | 1 | Core is about to start the next instruction |
| opcode_i | input | 8 | Fetched opcode |
| pc_ret_i | input | 16 | Address of the instruction about to run |
| pend_o | output | 13 | Pending flags |
| en_o | output | 13 | Enable flags |
| gie_o | output | 1 | Global enable |
| take_o | output | 1 | Interrupt taken this cycle |
| ir_o | output | 8 | Opcode delivered to the instruction register |
| busy_o | output | 1 | Entry sequence running (cycles 2 to 7) |
| push_we_o | output | 1 | Stack byte write strobe |
| push_data_o | output | 8 | Stack byte |
| pc_load_o | output | 1 | Program counter load strobe |
| pc_o | output | 16 | Program counter load value |
| done_o | output | 1 | Final cycle of the entry sequence |
| src_idx_o | output | 4 | Rank of the latched winner |
| vec_ofs_o | output | 16 | Byte offset of the winner's vector slot |

## Verification
The properties assume that `trap_enter_i` and `trap_exit_i` never pulse in the same cycle. They also assume that `pc_ret_i` describes the instruction at the boundary, because only its value in the take cycle matters. The checker keeps its own copy of the trap-service state from the two trap pulses and its own count of busy cycles. It takes the fixed 7-cycle entry as given.

The stimulus drives every request, clear, enable-set and trap signal as a one-cycle pulse, one at a time. It changes all inputs just after a clock edge. It raises `boundary_i` for exactly one cycle per attempt, and it also raises it while blocking conditions hold, so that the block's refusal to take is observed at the ports.

// File: rtl/vint_pkg.sv
package vint_pkg;
   localparam int unsigned BYTE_W = 8;

   // number of whole bytes in a word of the given width
   function automatic int unsigned bytes_of(input int unsigned w);
      return w / BYTE_W;
   endfunction
endpackage

// File: rtl/vint_flags.sv
module vint_flags #(
   parameter int unsigned MASK_N = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MASK_N-1:0] req_i,
   input  logic [MASK_N-1:0] clr_i,
   input  logic              en_wr_i,
   input  logic [MASK_N-1:0] en_data_i,
   output logic [MASK_N-1:0] pend_o,
   output logic [MASK_N-1:0] en_o
);
   for (genvar k = 0; k < MASK_N; k++) begin : g_src
      logic pend_q;
      logic en_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
            en_q   <= 1'b0;
         end else begin
            // a new request beats a software clear
            if (req_i[k])
               pend_q <= 1'b1;
            else if (clr_i[k])
               pend_q <= 1'b0;
            if (en_wr_i)
               en_q <= en_data_i[k];
         end
      end
      assign pend_o[k] = pend_q;
      assign en_o[k]   = en_q;
   end
endmodule

// File: rtl/vint_arb.sv
module vint_arb #(
   parameter int unsigned MASK_N = 13,
   parameter int unsigned IDX_W  = 4
) (
   input  logic [MASK_N-1:0] act_i,
   output logic              any_o,
   output logic [IDX_W-1:0]  idx_o
);
   // bit k of act_i is rank k+1; lower rank number wins
   always_comb begin
      idx_o = '0;
      for (int k = MASK_N - 1; k >= 0; k--) begin
         if (act_i[k])
            idx_o = IDX_W'(k + 1);
      end
   end
   assign any_o = |act_i;
endmodule

// File: rtl/vint_seq.sv
module vint_seq
   import vint_pkg::*;
#(
   parameter int unsigned          PC_W       = 16,
   parameter int unsigned          SEQ_CYC    = 7,
   parameter int unsigned          IDX_W      = 4,
   parameter logic [PC_W-1:0]      ENTRY_ADDR = 16'h00FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic [IDX_W-1:0]  win_idx_i,
   input  logic [PC_W-1:0]   pc_ret_i,
   output logic              busy_o,
   output logic              push_we_o,
   output logic [BYTE_W-1:0] push_data_o,
   output logic              pc_load_o,
   output logic [PC_W-1:0]   pc_o,
   output logic              done_o,
   output logic [IDX_W-1:0]  src_idx_o
);
   localparam int unsigned NB    = bytes_of(PC_W);
   localparam int unsigned CNT_W = $clog2(SEQ_CYC + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [PC_W-1:0]  ret_q;
   logic [IDX_W-1:0] idx_q;

   // cnt_q == 0 : idle; otherwise the current sequence cycle (2..SEQ_CYC)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ret_q <= '0;
         idx_q <= '0;
      end else if (take_i) begin
         cnt_q <= CNT_W'(2);
         ret_q <= pc_ret_i;
         idx_q <= win_idx_i;
      end else if (cnt_q == CNT_W'(SEQ_CYC)) begin
         cnt_q <= '0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   always_comb begin
      push_we_o   = 1'b0;
      push_data_o = '0;
      for (int k = 0; k < int'(NB); k++) begin
         if (cnt_q == CNT_W'(k + 2)) begin
            push_we_o   = 1'b1;
            push_data_o = ret_q[k*BYTE_W +: BYTE_W];
         end
      end
   end

   assign busy_o    = (cnt_q != '0);
   assign done_o    = (cnt_q == CNT_W'(SEQ_CYC));
   assign pc_load_o = done_o;
   assign pc_o      = done_o ? ENTRY_ADDR : '0;
   assign src_idx_o = idx_q;
endmodule

// File: rtl/vint_entry.sv
module vint_entry
   import vint_pkg::*;
#(
   parameter int unsigned     NUM_SRC    = 14,
   parameter int unsigned     PC_W       = 16,
   parameter int unsigned     OPC_W      = 8,
   parameter int unsigned     SEQ_CYC    = 7,
   parameter logic [PC_W-1:0] ENTRY_ADDR = 16'h00FF,
   parameter logic [OPC_W-1:0] INTR_OPC  = 8'h00,
   localparam int unsigned    MASK_N     = NUM_SRC - 1,
   localparam int unsigned    IDX_W      = $clog2(NUM_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MASK_N-1:0] req_i,
   input  logic [MASK_N-1:0] clr_i,
   input  logic              en_wr_i,
   input  logic [MASK_N-1:0] en_data_i,
   input  logic              gie_set_i,
   input  logic              trap_enter_i,
   input  logic              trap_exit_i,
   input  logic              boundary_i,
   input  logic [OPC_W-1:0]  opcode_i,
   input  logic [PC_W-1:0]   pc_ret_i,
   output logic [MASK_N-1:0] pend_o,
   output logic [MASK_N-1:0] en_o,
   output logic              gie_o,
   output logic              take_o,
   output logic [OPC_W-1:0]  ir_o,
   output logic              busy_o,
   output logic              push_we_o,
   output logic [BYTE_W-1:0] push_data_o,
   output logic              pc_load_o,
   output logic [PC_W-1:0]   pc_o,
   output logic              done_o,
   output logic [IDX_W-1:0]  src_idx_o,
   output logic [PC_W-1:0]   vec_ofs_o
);
   if (NUM_SRC < 2 || NUM_SRC > 64) begin : g_bad_src
      $error("vint_entry: NUM_SRC out of range");
   end
   if (PC_W % BYTE_W != 0 || PC_W < IDX_W + 2) begin : g_bad_pc
      $error("vint_entry: PC_W must be whole bytes and hold a vector offset");
   end
   if (SEQ_CYC < bytes_of(PC_W) + 2) begin : g_bad_len
      $error("vint_entry: SEQ_CYC too short for the return push");
   end

   logic              gie_q;
   logic              trap_q;
   logic              any_act;
   logic [IDX_W-1:0]  win_idx;

   vint_flags #(.MASK_N(MASK_N)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req_i),
      .clr_i    (clr_i),
      .en_wr_i  (en_wr_i),
      .en_data_i(en_data_i),
      .pend_o   (pend_o),
      .en_o     (en_o)
   );

   vint_arb #(.MASK_N(MASK_N), .IDX_W(IDX_W)) u_arb (
      .act_i(pend_o & en_o),
      .any_o(any_act),
      .idx_o(win_idx)
   );

   assign take_o = boundary_i && gie_q && any_act && !busy_o && !trap_q;
   assign ir_o   = take_o ? INTR_OPC : opcode_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q  <= 1'b0;
         trap_q <= 1'b0;
      end else begin
         if (take_o)
            gie_q <= 1'b0;
         else if (gie_set_i)
            gie_q <= 1'b1;
         if (trap_enter_i)
            trap_q <= 1'b1;
         else if (trap_exit_i)
            trap_q <= 1'b0;
      end
   end
   assign gie_o = gie_q;

   vint_seq #(
      .PC_W      (PC_W),
      .SEQ_CYC   (SEQ_CYC),
      .IDX_W     (IDX_W),
      .ENTRY_ADDR(ENTRY_ADDR)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_i     (take_o),
      .win_idx_i  (win_idx),
      .pc_ret_i   (pc_ret_i),
      .busy_o     (busy_o),
      .push_we_o  (push_we_o),
      .push_data_o(push_data_o),
      .pc_load_o  (pc_load_o),
      .pc_o       (pc_o),
      .done_o     (done_o),
      .src_idx_o  (src_idx_o)
   );

   // two-byte vector slots ordered by rank
   assign vec_ofs_o = {{(PC_W-IDX_W-1){1'b0}}, src_idx_o, 1'b0};
endmodule

// File: rtl/vint_entry_chk.sv
module vint_entry_chk #(
   parameter int unsigned      PC_W       = 16,
   parameter int unsigned      OPC_W      = 8,
   parameter int unsigned      SEQ_CYC    = 7,
   parameter int unsigned      IDX_W      = 4,
   parameter logic [PC_W-1:0]  ENTRY_ADDR = 16'h00FF,
   parameter logic [OPC_W-1:0] INTR_OPC   = 8'h00
) (
   input logic             clk,
   input logic             rst_n,
   input logic             take_o,
   input logic [OPC_W-1:0] ir_o,
   input logic             gie_o,
   input logic             boundary_i,
   input logic             trap_enter_i,
   input logic             trap_exit_i,
   input logic             busy_o,
   input logic             push_we_o,
   input logic [7:0]       push_data_o,
   input logic [PC_W-1:0]  pc_ret_i,
   input logic             pc_load_o,
   input logic [PC_W-1:0]  pc_o,
   input logic             done_o,
   input logic [IDX_W-1:0] src_idx_o
);
   logic       in_trap;
   logic [7:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_trap  <= 1'b0;
         busy_cnt <= '0;
      end else begin
         if (trap_enter_i)
            in_trap <= 1'b1;
         else if (trap_exit_i)
            in_trap <= 1'b0;
         busy_cnt <= busy_o ? busy_cnt + 8'd1 : 8'd0;
      end
   end

   // R3
   take_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (boundary_i && gie_o && !busy_o));
   // R5
   opc_subst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (ir_o == INTR_OPC));
   // R6
   gie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> !gie_o);
   // R7
   push_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> (push_we_o && push_data_o == $past(pc_ret_i[7:0])));
   // R7
   push_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_we_o && $past(push_we_o)) |-> (push_data_o == $past(pc_ret_i[15:8], 2)));
   // R7
   push_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_we_o |-> busy_o);
   // R8
   entry_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (busy_cnt == 8'(SEQ_CYC - 2) && pc_load_o && pc_o == ENTRY_ADDR));
   // R4
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(src_idx_o));
   // R9
   trap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> !in_trap);
endmodule

bind vint_entry vint_entry_chk #(
   .PC_W      (PC_W),
   .OPC_W     (OPC_W),
   .SEQ_CYC   (SEQ_CYC),
   .IDX_W     (IDX_W),
   .ENTRY_ADDR(ENTRY_ADDR),
   .INTR_OPC  (INTR_OPC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .take_o      (take_o),
   .ir_o        (ir_o),
   .gie_o       (gie_o),
   .boundary_i  (boundary_i),
   .trap_enter_i(trap_enter_i),
   .trap_exit_i (trap_exit_i),
   .busy_o      (busy_o),
   .push_we_o   (push_we_o),
   .push_data_o (push_data_o),
   .pc_ret_i    (pc_ret_i),
   .pc_load_o   (pc_load_o),
   .pc_o        (pc_o),
   .done_o      (done_o),
   .src_idx_o   (src_idx_o)
);

// File: tb/tb_vint_entry.sv
`timescale 1ns/1ps
module tb_vint_entry;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] req_i = '0, clr_i = '0, en_data_i = '0;
   logic        en_wr_i = 0, gie_set_i = 0, trap_enter_i = 0, trap_exit_i = 0;
   logic        boundary_i = 0;
   logic [7:0]  opcode_i = 8'h5A;
   logic [15:0] pc_ret_i = '0;
   logic [12:0] pend_o, en_o;
   logic        gie_o, take_o, busy_o, push_we_o, pc_load_o, done_o;
   logic [7:0]  ir_o, push_data_o;
   logic [15:0] pc_o, vec_ofs_o;
   logic [3:0]  src_idx_o;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   vint_entry dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr_i),
      .en_wr_i(en_wr_i), .en_data_i(en_data_i), .gie_set_i(gie_set_i),
      .trap_enter_i(trap_enter_i), .trap_exit_i(trap_exit_i),
      .boundary_i(boundary_i), .opcode_i(opcode_i), .pc_ret_i(pc_ret_i),
      .pend_o(pend_o), .en_o(en_o), .gie_o(gie_o), .take_o(take_o),
      .ir_o(ir_o), .busy_o(busy_o), .push_we_o(push_we_o),
      .push_data_o(push_data_o), .pc_load_o(pc_load_o), .pc_o(pc_o),
      .done_o(done_o), .src_idx_o(src_idx_o), .vec_ofs_o(vec_ofs_o)
   );

   // vectors: enable mask, request mask, expected winner rank (0 = none)
   localparam int NV = 6;
   localparam logic [12:0] V_EN  [NV] = '{13'h1FFF, 13'h1FFF, 13'h1000, 13'h00F0, 13'h0A00, 13'h0001};
   localparam logic [12:0] V_REQ [NV] = '{13'h0002, 13'h1004, 13'h1FFF, 13'h0F00, 13'h0E00, 13'h0001};
   localparam logic [3:0]  V_WIN [NV] = '{4'd2, 4'd3, 4'd13, 4'd0, 4'd10, 4'd1};

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic pulse_clr_all();
      clr_i = '1; step(); clr_i = '0;
   endtask

   // runs cycles 2..7 after a take in the current cycle, then one idle cycle
   task automatic run_entry(input logic [3:0] win, input logic [15:0] ret);
      step();
      boundary_i = 0;
      chk(busy_o == 1, "R8", "busy c2", busy_o, 1);
      chk(gie_o == 0, "R6", "gie c2", gie_o, 0);
      chk(push_we_o && push_data_o == ret[7:0], "R7", "push lo", push_data_o, ret[7:0]);
      chk(src_idx_o == win, "R4", "winner", src_idx_o, win);
      chk(vec_ofs_o == {11'd0, win, 1'b0}, "R10", "vec ofs", vec_ofs_o, {11'd0, win, 1'b0});
      step();
      chk(push_we_o && push_data_o == ret[15:8], "R7", "push hi", push_data_o, ret[15:8]);
      for (int c = 4; c <= 6; c++) begin
         step();
         chk(busy_o && !push_we_o && !done_o && !pc_load_o, "R8", "mid cycle",
             {busy_o, push_we_o, done_o, pc_load_o}, 4'b1000);
         chk(src_idx_o == win, "R4", "winner held", src_idx_o, win);
      end
      step();
      chk(done_o && pc_load_o && pc_o == 16'h00FF, "R8", "final pc", pc_o, 16'h00FF);
      step();
      chk(!busy_o && !done_o, "R8", "idle after", {busy_o, done_o}, 0);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #2;
      // R1 reset state
      chk(gie_o == 0 && pend_o == 0 && en_o == 0, "R1", "flags", {gie_o, pend_o, en_o}, 0);
      chk(!busy_o && !take_o && !push_we_o && !pc_load_o && !done_o, "R1", "strobes",
          {busy_o, take_o, push_we_o, pc_load_o, done_o}, 0);
      chk(ir_o == opcode_i, "R1", "ir pass", ir_o, opcode_i);
      step(); step();
      rst_n = 1;
      step();

      // table walk
      for (int i = 0; i < NV; i++) begin
         pulse_clr_all();
         en_wr_i = 1; en_data_i = V_EN[i]; step(); en_wr_i = 0;
         chk(en_o == V_EN[i], "R2", "enable load", en_o, V_EN[i]);
         req_i = V_REQ[i]; step(); req_i = '0;
         chk(pend_o == V_REQ[i], "R2", "pending set", pend_o, V_REQ[i]);
         gie_set_i = 1; step(); gie_set_i = 0;
         chk(gie_o == 1, "R6", "gie set", gie_o, 1);
         boundary_i = 1; opcode_i = 8'h5A; pc_ret_i = 16'h1200 + 16'(i * 16'h0111);
         #1;
         if (V_WIN[i] == 0) begin
            chk(!take_o, "R3", "no active source", take_o, 0);
            chk(ir_o == 8'h5A, "R5", "ir pass", ir_o, 8'h5A);
            step(); boundary_i = 0;
         end else begin
            chk(take_o, "R3", "take", take_o, 1);
            chk(ir_o == 8'h00, "R5", "ir forced", ir_o, 8'h00);
            run_entry(V_WIN[i], 16'h1200 + 16'(i * 16'h0111));
         end
      end

      // R2 request beats same-cycle clear, clear alone works
      pulse_clr_all();
      req_i = 13'h0010; step(); req_i = '0;
      req_i = 13'h0010; clr_i = 13'h0010; step(); req_i = '0; clr_i = '0;
      chk(pend_o[4] == 1, "R2", "req wins over clr", pend_o, 13'h0010);
      clr_i = 13'h0010; step(); clr_i = '0;
      chk(pend_o[4] == 0, "R2", "clr", pend_o, 0);

      // R3 global enable low blocks; boundary low blocks
      pulse_clr_all();
      en_wr_i = 1; en_data_i = 13'h1FFF; step(); en_wr_i = 0;
      req_i = 13'h0008; step(); req_i = '0;
      boundary_i = 1; #1;
      chk(gie_o == 0 && !take_o, "R3", "gie low blocks", take_o, 0);
      step(); boundary_i = 0;
      gie_set_i = 1; step(); gie_set_i = 0;
      #1;
      chk(!take_o, "R3", "no boundary no take", take_o, 0);
      step();

      // R9 trap service blocks maskable entry
      trap_enter_i = 1; step(); trap_enter_i = 0;
      boundary_i = 1; opcode_i = 8'hC3; #1;
      chk(!take_o, "R9", "trap blocks", take_o, 0);
      chk(ir_o == 8'hC3, "R9", "ir pass in trap", ir_o, 8'hC3);
      step(); boundary_i = 0;
      chk(!busy_o && gie_o, "R9", "no entry in trap", {busy_o, gie_o}, 2'b01);
      trap_exit_i = 1; step(); trap_exit_i = 0;
      boundary_i = 1; pc_ret_i = 16'hBEEF; #1;
      chk(take_o && ir_o == 8'h00, "R9", "take after exit", {take_o, ir_o}, 9'h100);
      run_entry(4'd4, 16'hBEEF);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule